// File: doc/BRIEF.md
# SPI Input Expander with Maskable Interrupt

This block is the digital core of a general-purpose input device with a 16-bit input bus that an SPI controller reads. Chip select falling freezes the input levels into a status register. The first rising edge of the serial clock after that moves the frozen value into a shift register. The bits then leave on the serial output, most significant first. In the same frame the controller shifts in a new interrupt mask on the serial input. The block commits that mask when chip select returns high.

An interrupt flags any enabled input that has moved away from its frozen value. It is active low and built for an open-drain pad, so several devices can share one pull-up. Because the shift register is a plain 16-bit delay line, devices chain serial output to serial input on a shared clock and select. After 16 clocks per device, each device holds the mask meant for it.

All pins are oversampled by the system clock through two-flop synchronizers. The system clock must therefore run at least four times faster than the serial clock.

Top module: `spi_gpi_core`

## Requirements
- R1: On the falling edge of chip select, the 16 input levels are frozen into the status register. Input changes later in the frame do not alter the data read out in that frame.
- R2: The first serial clock rising edge after chip select falls loads the shift register from the status register, and bit 15 appears on `sdout_o`.
- R3: Each following rising edge presents the next lower status bit, so a 16-clock frame reads the status bits in the order 15 down to 0.
- R4: `sdin_i` is sampled on serial clock falling edges, and only while chip select is low. Serial clock toggles while chip select is high cause no load, no shift and no output enable.
- R5: On the rising edge of chip select, the shift register becomes the interrupt mask. In a 16-clock frame, the first bit sent lands in mask bit 15 and the last in mask bit 0.
- R6: Past 16 clocks, `sdout_o` replays the `sdin_i` bits received 16 clocks earlier. With 32 clocks, the second 16 bits read equal the first 16 bits sent.
- R7: `sdout_oe_o` is 0 while chip select is high and 1 while it is low.
- R8: The interrupt asserts (`int_n_o`=0, `int_oe_o`=1) when any input whose mask bit is 1 differs from its frozen status bit. A mask bit of 0 keeps that input from asserting it.
- R9: A falling edge of chip select releases the interrupt.
- R10: After reset the mask is all ones, the status register is zero, the interrupt is released and `sdout_oe_o` is 0.
- R11: Once asserted, the interrupt stays asserted until a chip select falling edge, even if the input returns to its frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| sdin_i | input | 1 | Serial data in (mask bits, chain input) |
| sdout_o | output | 1 | Serial data out value |
| sdout_oe_o | output | 1 | Output enable for the serial data out pad |
| data_i | input | 16 | Parallel input lines |
| int_n_o | output | 1 | Interrupt level, low when asserted |
| int_oe_o | output | 1 | Pull-down enable for the open-drain interrupt pad |

## Verification
Several corner cases are targeted directly. An input change just after chip select falls must not leak into the readout; a design that loaded from the live pins would return the new value. Stray serial clocks while deselected are followed by a normal read; a design that counted them would skip the parallel load and return shifted garbage. Single-bit masks at bit 0 and bit 15 expose a reversed or misaligned mask. A 32-clock frame shows whether bits past the sixteenth replay the serial input as a delay line or repeat stale status. The interrupt is checked for sticky behaviour after the input reverts, and for release on chip select falling.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  localparam int GPI_W = 16;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic sclk_fall;
  } spi_ev_t;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/gpi_spi_edges.sv
module gpi_spi_edges
  import gpi_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_s_i,
  input  logic    sclk_s_i,
  output spi_ev_t ev_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s_i;
      sclk_q <= sclk_s_i;
    end
  end

  assign ev_o.cs_fall   = cs_q & ~cs_s_i;
  assign ev_o.cs_rise   = ~cs_q & cs_s_i;
  // serial clock edges only count while selected
  assign ev_o.sclk_rise = ~cs_s_i & ~sclk_q & sclk_s_i;
  assign ev_o.sclk_fall = ~cs_s_i & sclk_q & ~sclk_s_i;

  p_ev_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_o.cs_fall, ev_o.cs_rise, ev_o.sclk_rise, ev_o.sclk_fall}));
  p_no_clk_desel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |-> !(ev_o.sclk_rise || ev_o.sclk_fall));
endmodule

// File: rtl/gpi_spi_shift.sv
module gpi_spi_shift
  import gpi_pkg::*;
#(
  parameter int W = GPI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  spi_ev_t      ev_i,
  input  logic         cs_s_i,
  input  logic         sdin_s_i,
  input  logic [W-1:0] data_s_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         sdout_o,
  output logic         sdout_oe_o
);
  logic [W-1:0] status_q, sh_q, mask_q;
  logic         first_q, sdout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      sh_q     <= '0;
      mask_q   <= '1;
      first_q  <= 1'b0;
      sdout_q  <= 1'b0;
    end else begin
      if (ev_i.cs_fall) begin
        status_q <= data_s_i;
        first_q  <= 1'b1;
      end
      if (ev_i.sclk_rise) begin
        first_q <= 1'b0;
        if (first_q) begin
          sh_q    <= status_q;
          sdout_q <= status_q[W-1];
        end else begin
          sdout_q <= sh_q[W-1];
        end
      end
      if (ev_i.sclk_fall) sh_q <= {sh_q[W-2:0], sdin_s_i};
      if (ev_i.cs_rise)   mask_q <= sh_q;
    end
  end

  assign status_o   = status_q;
  assign mask_o     = mask_q;
  assign sdout_o    = sdout_q;
  assign sdout_oe_o = ~cs_s_i;

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.cs_fall |=> status_q == $past(data_s_i));
  p_status_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.cs_fall |=> $stable(status_q));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.sclk_rise && first_q) |=>
      (sh_q == $past(status_q)) && (sdout_q == $past(status_q[W-1])));
  p_shift_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.sclk_fall |=> sh_q == {$past(sh_q[W-2:0]), $past(sdin_s_i)});
  p_mask_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.cs_rise |=> mask_q == $past(sh_q));
endmodule

// File: rtl/gpi_irq.sv
module gpi_irq #(
  parameter int W = gpi_pkg::GPI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_s_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         irq_o
);
  logic [W-1:0] hit;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_hit
    assign hit[i] = mask_i[i] & (data_s_i[i] ^ status_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else if (|hit)  irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_q);
  p_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(|(mask_i & (data_s_i ^ status_i))));
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
endmodule

// File: rtl/spi_gpi_core.sv
module spi_gpi_core
  import gpi_pkg::*;
#(
  parameter int W = GPI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         sclk_i,
  input  logic         sdin_i,
  output logic         sdout_o,
  output logic         sdout_oe_o,
  input  logic [W-1:0] data_i,
  output logic         int_n_o,
  output logic         int_oe_o
);
  localparam int SW = W + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] sync_q;
  logic          cs_s, sclk_s, sdin_s;
  logic [W-1:0]  data_s, status, mask;
  spi_ev_t       ev;
  logic          irq;

  gpi_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdin_i, data_i}),
    .q_o   (sync_q)
  );

  assign {cs_s, sclk_s, sdin_s, data_s} = sync_q;

  gpi_spi_edges u_edges (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_i  (cs_s),
    .sclk_s_i(sclk_s),
    .ev_o    (ev)
  );

  gpi_spi_shift #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .cs_s_i    (cs_s),
    .sdin_s_i  (sdin_s),
    .data_s_i  (data_s),
    .status_o  (status),
    .mask_o    (mask),
    .sdout_o   (sdout_o),
    .sdout_oe_o(sdout_oe_o)
  );

  gpi_irq #(.W(W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_s_i(data_s),
    .status_i(status),
    .mask_i  (mask),
    .clr_i   (ev.cs_fall),
    .irq_o   (irq)
  );

  assign int_n_o  = ~irq;
  assign int_oe_o = irq;

  p_int_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_n_o != int_oe_o);
  p_oe_desel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.cs_rise |=> !sdout_oe_o);
endmodule

// File: tb/spi_gpi_core_test.sv
`timescale 1ns/1ps
module spi_gpi_core_test;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, sdin;
  logic [15:0] data;
  logic        sdout, sdout_oe, int_n, int_oe;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] miso;
  logic        oe_ok;

  always #4 clk = ~clk;

  spi_gpi_core uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .sdout_o(sdout), .sdout_oe_o(sdout_oe), .data_i(data),
    .int_n_o(int_n), .int_oe_o(int_oe)
  );

  // {input levels, mask sent}
  localparam logic [31:0] VEC [6] = '{
    {16'hA5C3, 16'hFFFF}, {16'h0001, 16'h8000}, {16'h8000, 16'h0001},
    {16'hFFFF, 16'h0000}, {16'h0000, 16'h5A5A}, {16'h1234, 16'hFFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [31:0] mosi, input logic chg,
                       input logic [15:0] chg_val, output logic [31:0] rd,
                       output logic oe_all);
    rd = '0;
    oe_all = 1'b1;
    cs_n = 1'b0;
    wait_clk(6);
    if (chg) begin
      data = chg_val;
      wait_clk(4);
    end
    for (int i = 0; i < n; i++) begin
      sdin = mosi[n-1-i];
      sclk = 1'b1;
      wait_clk(4);
      rd[n-1-i] = sdout;
      oe_all &= sdout_oe;
      sclk = 1'b0;
      wait_clk(4);
    end
    wait_clk(2);
    cs_n = 1'b1;
    sdin = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdin = 1'b0; data = '0;
    wait_clk(5);
    check("R10 int_n reset", int_n, 1);
    check("R10 int_oe reset", int_oe, 0);
    check("R10 sdout_oe reset", sdout_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // reset mask all ones, status zero: any input high raises interrupt
    data = 16'h0400;
    wait_clk(6);
    check("R10 R8 int after reset", {int_n, int_oe}, 2'b01);
    data = 16'h0000;
    wait_clk(6);
    check("R11 int sticky", int_oe, 1);
    frame(16, 32'hFFFF, 1'b0, 16'h0, miso, oe_ok);
    check("R9 int cleared by cs fall", {int_n, int_oe}, 2'b10);
    check("R2 read zero", miso[15:0], 16'h0000);

    foreach (VEC[k]) begin
      data = VEC[k][31:16];
      wait_clk(6);
      frame(16, {16'h0, VEC[k][15:0]}, 1'b0, 16'h0, miso, oe_ok);
      check("R2 R3 readout", miso[15:0], VEC[k][31:16]);
      check("R7 oe while selected", oe_ok, 1);
      check("R7 oe after deselect", sdout_oe, 0);
      check("R9 no int at rest", int_oe, 0);
    end

    // R8: mask only bit 0
    frame(16, 32'h0001, 1'b0, 16'h0, miso, oe_ok);
    data = 16'h1234 ^ 16'h0020;
    wait_clk(6);
    check("R8 masked input ignored", int_oe, 0);
    data = 16'h1234 ^ 16'h0001;
    wait_clk(6);
    check("R8 unmasked input raises", {int_n, int_oe}, 2'b01);

    // R5: first bit sent lands at mask bit 15
    frame(16, 32'h8000, 1'b0, 16'h0, miso, oe_ok);
    check("R9 cleared", int_oe, 0);
    data = data ^ 16'h4000;
    wait_clk(6);
    check("R5 bit14 masked", int_oe, 0);
    data = data ^ 16'h8000;
    wait_clk(6);
    check("R5 bit15 enabled", int_oe, 1);

    // R1: change inputs after cs fall
    data = 16'h0F0F;
    wait_clk(6);
    frame(16, 32'hFFFF, 1'b1, 16'hF0F0, miso, oe_ok);
    check("R1 frozen readout", miso[15:0], 16'h0F0F);

    // R4: stray clocks while deselected
    sdin = 1'b1;
    oe_ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; wait_clk(4); oe_ok &= ~sdout_oe;
      sclk = 1'b0; wait_clk(4); oe_ok &= ~sdout_oe;
    end
    sdin = 1'b0;
    check("R4 no oe when deselected", oe_ok, 1);
    frame(16, 32'hFFFF, 1'b0, 16'h0, miso, oe_ok);
    check("R4 R2 read after stray clocks", miso[15:0], 16'hF0F0);

    // R6: 32-clock frame acts as delay line
    data = 16'h3C3C;
    wait_clk(6);
    frame(32, {16'hBEEF, 16'hFFFF}, 1'b0, 16'h0, miso, oe_ok);
    check("R3 first word", miso[31:16], 16'h3C3C);
    check("R6 delayed sdin", miso[15:0], 16'hBEEF);
    data = 16'h3C3D;
    wait_clk(6);
    check("R5 last 16 bits form mask", int_oe, 1);

    // mask all zero suppresses everything
    frame(16, 32'h0000, 1'b0, 16'h0, miso, oe_ok);
    data = 16'hC3C2;
    wait_clk(6);
    check("R8 zero mask", {int_n, int_oe}, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule